// File: doc/BRIEF.md
# Aperture Window Address Remapper

This block sits behind a 1 MB host-visible memory aperture and turns each single-word host request into a request on a 32 MB internal bus with a 25-bit address. Offsets in the lower 512 KB of the aperture reach the same internal address with no change. Offsets in the upper 512 KB are steered by a window register. The register's 6-bit index supplies the top internal address bits, and the low 19 offset bits are kept.

The window register is part of the block and sits at aperture offset 0x310C, which is in the untranslated half. Software writes an index and sets the enable bit. It can read the register back to confirm the write, and every later request uses the new window. If the upper half is accessed while the window is disabled, the request never reaches the internal bus. Reads return zero, writes are dropped, and a sticky error flag is set. Software reads that flag at offset 0x3110 and clears it there.

Requests are handled one at a time with a valid/ready handshake on both sides. Read data comes back as a one-cycle response pulse.

Top module: `win_remap`

## Requirements
- R1: After reset the host side is ready, no internal request is pending, the error flag is clear, and both the window register (0x310C) and the status register (0x3110) read as zero.
- R2: A request at an aperture offset below 0x80000, other than 0x310C and 0x3110, is forwarded with the internal address equal to the offset, zero-extended to 25 bits.
- R3: A request at an offset from 0x80000 to 0xFFFFF is forwarded while the window is enabled. Its internal address is the window index in bits [24:19] and offset bits [18:0] in bits [18:0].
- R4: The window register at 0x310C holds 32 bits. Bits [5:0] are the index and bit EN_BIT (default 30) is the enable; no other bit enables the window. A read returns exactly the last value written, and accesses to this register are never forwarded.
- R5: A write to the window register applies to the request accepted in the very next cycle.
- R6: While the enable bit is clear, an upper-half read returns zero and an upper-half write is dropped. Neither produces an internal request, and either one sets the error flag: status bit 0 at offset 0x3110 and the win_err output.
- R7: The error flag stays set until a write to 0x3110 with data bit 0 equal to 1. A write there with bit 0 clear leaves it set.
- R8: Write data reaches the internal bus unchanged, and internal read data is returned to the host unchanged.
- R9: Only one request is in flight. host_ready is low while an internal request is pending, and the internal request's valid, address, write flag and data hold steady until bus_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can accept a host request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Byte offset within the aperture |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | One-cycle read response strobe |
| host_rdata | output | 32 | Read response data |
| bus_valid | output | 1 | Internal request valid |
| bus_ready | input | 1 | Internal bus accepts the request |
| bus_write | output | 1 | Internal request is a write |
| bus_addr | output | 25 | Internal byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_rvalid | input | 1 | Internal read data strobe |
| bus_rdata | input | 32 | Internal read data |
| win_err | output | 1 | Sticky disabled-window access flag |

## Verification
Two functions can meet on the same clock edge: a window-register update and the translation of the request that follows it. The translator reads the register output in the first cycle after the update. The bench writes a new index and then presents an upper-half read in the next cycle with no idle gap. It repeats this with a write at a second index. Each case is judged by the internal address the responder sees: any stale index would put a different value in the top six bits. The same back-to-back pattern is used to clear the error flag and read it in the next cycle.

// File: rtl/win_remap_pkg.sv
package win_remap_pkg;

  // sequencing state of the request path
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_RDW  = 2'd2
  } fsm_t;

  // where a decoded host request goes
  typedef enum logic [1:0] {
    TGT_CTRL  = 2'd0,
    TGT_STAT  = 2'd1,
    TGT_BUS   = 2'd2,
    TGT_BLOCK = 2'd3
  } tgt_t;

endpackage

// File: rtl/win_addr_xlate.sv
module win_addr_xlate
  import win_remap_pkg::*;
#(
  parameter int              AP_AW    = 20,
  parameter int              IDX_W    = 6,
  parameter logic [AP_AW-1:0] CTRL_OFF = 20'h0310C,
  parameter logic [AP_AW-1:0] STAT_OFF = 20'h03110,
  localparam int             SPLIT    = AP_AW - 1,
  localparam int             IN_AW    = IDX_W + SPLIT
)(
  input  logic [AP_AW-1:0] ap_addr,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             win_en,
  output tgt_t             tgt,
  output logic [IN_AW-1:0] in_addr
);

  logic upper;
  assign upper = ap_addr[SPLIT];

  always_comb begin
    if (upper) begin
      in_addr = {win_idx, ap_addr[SPLIT-1:0]};
      tgt     = win_en ? TGT_BUS : TGT_BLOCK;
    end else begin
      in_addr = {{IDX_W{1'b0}}, ap_addr[SPLIT-1:0]};
      if (ap_addr == CTRL_OFF)      tgt = TGT_CTRL;
      else if (ap_addr == STAT_OFF) tgt = TGT_STAT;
      else                          tgt = TGT_BUS;
    end
  end

endmodule

// File: rtl/win_ctrl_regs.sv
module win_ctrl_regs #(
  parameter int DW     = 32,
  parameter int IDX_W  = 6,
  parameter int EN_BIT = 30
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             stat_we,
  input  logic             err_set,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    ctrl_q,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_en,
  output logic             err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (err_set) begin
      err_q <= 1'b1;
    end else if (stat_we && wdata[0]) begin
      err_q <= 1'b0;
    end
  end

  assign win_idx = ctrl_q[IDX_W-1:0];

  generate
    if (EN_BIT < DW) begin : g_en_in_range
      assign win_en = ctrl_q[EN_BIT];
    end else begin : g_en_absent
      assign win_en = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/win_req_fsm.sv
module win_req_fsm
  import win_remap_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IN_AW = 25
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             host_valid,
  input  logic             host_write,
  input  logic [DW-1:0]    host_wdata,
  output logic             host_ready,
  output logic             host_rvalid,
  output logic [DW-1:0]    host_rdata,
  input  tgt_t             tgt,
  input  logic [IN_AW-1:0] in_addr,
  input  logic [DW-1:0]    ctrl_q,
  input  logic             err_q,
  output logic             ctrl_we,
  output logic             stat_we,
  output logic             err_set,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_write,
  output logic [IN_AW-1:0] bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_rvalid,
  input  logic [DW-1:0]    bus_rdata
);

  fsm_t state;
  logic accept;

  assign host_ready = (state == ST_IDLE);
  assign accept     = host_valid && host_ready;
  assign ctrl_we    = accept && host_write && (tgt == TGT_CTRL);
  assign stat_we    = accept && host_write && (tgt == TGT_STAT);
  assign err_set    = accept && (tgt == TGT_BLOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      bus_valid   <= 1'b0;
      bus_write   <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
    end else begin
      host_rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (host_valid) begin
            case (tgt)
              TGT_CTRL: begin
                if (!host_write) begin
                  host_rvalid <= 1'b1;
                  host_rdata  <= ctrl_q;
                end
              end
              TGT_STAT: begin
                if (!host_write) begin
                  host_rvalid <= 1'b1;
                  host_rdata  <= {{(DW-1){1'b0}}, err_q};
                end
              end
              TGT_BLOCK: begin
                if (!host_write) begin
                  host_rvalid <= 1'b1;
                  host_rdata  <= '0;
                end
              end
              default: begin
                bus_valid <= 1'b1;
                bus_write <= host_write;
                bus_addr  <= in_addr;
                bus_wdata <= host_wdata;
                state     <= ST_FWD;
              end
            endcase
          end
        end
        ST_FWD: begin
          if (bus_ready) begin
            bus_valid <= 1'b0;
            state     <= bus_write ? ST_IDLE : ST_RDW;
          end
        end
        ST_RDW: begin
          if (bus_rvalid) begin
            host_rvalid <= 1'b1;
            host_rdata  <= bus_rdata;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/win_remap.sv
module win_remap
  import win_remap_pkg::*;
#(
  parameter int               AP_AW    = 20,
  parameter int               IDX_W    = 6,
  parameter int               DW       = 32,
  parameter int               EN_BIT   = 30,
  parameter logic [AP_AW-1:0] CTRL_OFF = 20'h0310C,
  parameter logic [AP_AW-1:0] STAT_OFF = 20'h03110,
  localparam int              IN_AW    = IDX_W + AP_AW - 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_write,
  input  logic [AP_AW-1:0] host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic             host_rvalid,
  output logic [DW-1:0]    host_rdata,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_write,
  output logic [IN_AW-1:0] bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_rvalid,
  input  logic [DW-1:0]    bus_rdata,
  output logic             win_err
);

  tgt_t             tgt;
  logic [IN_AW-1:0] in_addr;
  logic [DW-1:0]    ctrl_q;
  logic [IDX_W-1:0] win_idx;
  logic             win_en;
  logic             ctrl_we;
  logic             stat_we;
  logic             err_set;

  win_addr_xlate #(
    .AP_AW   (AP_AW),
    .IDX_W   (IDX_W),
    .CTRL_OFF(CTRL_OFF),
    .STAT_OFF(STAT_OFF)
  ) u_xlate (
    .ap_addr(host_addr),
    .win_idx(win_idx),
    .win_en (win_en),
    .tgt    (tgt),
    .in_addr(in_addr)
  );

  win_ctrl_regs #(
    .DW    (DW),
    .IDX_W (IDX_W),
    .EN_BIT(EN_BIT)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .ctrl_we(ctrl_we),
    .stat_we(stat_we),
    .err_set(err_set),
    .wdata  (host_wdata),
    .ctrl_q (ctrl_q),
    .win_idx(win_idx),
    .win_en (win_en),
    .err_q  (win_err)
  );

  win_req_fsm #(
    .DW   (DW),
    .IN_AW(IN_AW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_write (host_write),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .host_rvalid(host_rvalid),
    .host_rdata (host_rdata),
    .tgt        (tgt),
    .in_addr    (in_addr),
    .ctrl_q     (ctrl_q),
    .err_q      (win_err),
    .ctrl_we    (ctrl_we),
    .stat_we    (stat_we),
    .err_set    (err_set),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata)
  );

endmodule

// File: rtl/win_remap_chk.sv
module win_remap_chk #(
  parameter int               AP_AW    = 20,
  parameter int               IN_AW    = 25,
  parameter int               DW       = 32,
  parameter logic [AP_AW-1:0] STAT_OFF = 20'h03110
)(
  input logic             clk,
  input logic             rst,
  input logic             host_valid,
  input logic             host_ready,
  input logic             host_write,
  input logic [AP_AW-1:0] host_addr,
  input logic [DW-1:0]    host_wdata,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic             bus_write,
  input logic [IN_AW-1:0] bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             win_err,
  input logic             win_en
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_valid && host_ready && !win_err));

  a_r2_issue_from_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> $past(host_valid && host_ready));

  a_r2_lower_identity: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_valid) && !$past(host_addr[AP_AW-1]))
      |-> (bus_addr == IN_AW'($past(host_addr))));

  a_r6_no_bus_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_ready && host_addr[AP_AW-1] && !win_en) |=> !bus_valid);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (win_err && !(host_valid && host_ready && host_write &&
                  host_addr == STAT_OFF && host_wdata[0])) |=> win_err);

  a_r9_single_flight: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !host_ready);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

endmodule

bind win_remap win_remap_chk #(
  .AP_AW   (AP_AW),
  .IN_AW   (IN_AW),
  .DW      (DW),
  .STAT_OFF(STAT_OFF)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_valid(host_valid),
  .host_ready(host_ready),
  .host_write(host_write),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .win_err   (win_err),
  .win_en    (win_en)
);

// File: tb/win_remap_tb_top.sv
`timescale 1ns/1ps
module win_remap_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic [19:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        bus_valid;
  logic        bus_ready;
  logic        bus_write;
  logic [24:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_rvalid = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        win_err;

  logic        stall = 1'b0;
  int          wr_cnt = 0;
  logic [24:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  win_remap dut_i (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_write (host_write),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rvalid(host_rvalid),
    .host_rdata (host_rdata),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .win_err    (win_err)
  );

  function automatic logic [31:0] pat(input logic [24:0] a);
    return 32'hC300_0000 ^ {7'b0, a};
  endfunction

  // internal bus responder
  assign bus_ready = !stall;
  always @(posedge clk) begin
    bus_rvalid <= bus_valid && bus_ready && !bus_write;
    bus_rdata  <= pat(bus_addr);
    if (bus_valid && bus_ready && bus_write) begin
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= bus_addr;
      wr_data <= bus_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [19:0] a, input logic [31:0] d);
    int g = 0;
    while (!host_ready && g < 200) begin
      @(negedge clk);
      g++;
    end
    host_valid = 1'b1;
    host_write = wr;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic host_read(input logic [19:0] a, output logic [31:0] d);
    int g = 0;
    issue(1'b0, a, 32'h0);
    while (!host_rvalid && g < 100) begin
      @(negedge clk);
      g++;
    end
    if (!host_rvalid) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8: actual no read response expected response at 0x%05h", a);
      d = 32'hxxxx_xxxx;
    end else begin
      d = host_rdata;
    end
  endtask

  task automatic wait_wr(input int prev);
    int g = 0;
    while (wr_cnt == prev && g < 50) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 host_ready", 32'(host_ready), 32'd1);
    check("R1 bus_valid", 32'(bus_valid), 32'd0);
    check("R1 win_err", 32'(win_err), 32'd0);
    host_read(20'h0310C, d);
    check("R1 ctrl reset value", d, 32'h0);
    host_read(20'h03110, d);
    check("R1 status reset value", d, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] d;
    int p = wr_cnt;
    issue(1'b1, 20'h00120, 32'h1357_9BDF);
    wait_wr(p);
    check("R2 direct write addr", 32'(wr_addr), 32'h0000_0120);
    check("R8 direct write data", wr_data, 32'h1357_9BDF);
    host_read(20'h7FFFC, d);
    check("R2 R8 direct read data", d, pat(25'h007FFFC));
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    int p = wr_cnt;
    issue(1'b1, 20'h0310C, 32'h5230_0015);
    host_read(20'h0310C, d);
    check("R4 ctrl readback", d, 32'h5230_0015);
    repeat (3) @(negedge clk);
    check("R4 ctrl not forwarded", 32'(wr_cnt), 32'(p));
  endtask

  task automatic t_window();
    logic [31:0] d;
    int p;
    host_read(20'h80010, d);
    check("R3 window read", d, pat({6'h15, 19'h00010}));
    p = wr_cnt;
    issue(1'b1, 20'hFFFFC, 32'hA5A5_0F0F);
    wait_wr(p);
    check("R3 window write addr", 32'(wr_addr), 32'({6'h15, 19'h7FFFC}));
    check("R8 window write data", wr_data, 32'hA5A5_0F0F);
  endtask

  task automatic t_back2back();
    logic [31:0] d;
    int p;
    issue(1'b1, 20'h0310C, 32'h4000_003F);
    host_read(20'h80004, d);
    check("R5 next-cycle read uses new index", d, pat({6'h3F, 19'h00004}));
    p = wr_cnt;
    issue(1'b1, 20'h0310C, 32'h4000_0002);
    issue(1'b1, 20'h80008, 32'h0BAD_F00D);
    wait_wr(p);
    check("R5 next-cycle write uses new index", 32'(wr_addr), 32'({6'h02, 19'h00008}));
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    int p;
    issue(1'b1, 20'h0310C, 32'h8000_0001);
    p = wr_cnt;
    host_read(20'h90000, d);
    check("R4 R6 bit31 does not enable, read zero", d, 32'h0);
    check("R6 err after disabled read", 32'(win_err), 32'd1);
    issue(1'b1, 20'hA0000, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    check("R6 disabled write dropped", 32'(wr_cnt), 32'(p));
    host_read(20'h03110, d);
    check("R6 status bit set", d, 32'h1);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    int p = wr_cnt;
    issue(1'b1, 20'h03110, 32'hFFFF_FFFE);
    host_read(20'h03110, d);
    check("R7 write of 0 keeps flag", d, 32'h1);
    issue(1'b1, 20'h00200, 32'h2222_2222);
    wait_wr(p);
    check("R7 flag kept over normal access", 32'(win_err), 32'd1);
    issue(1'b1, 20'h03110, 32'h0000_0001);
    host_read(20'h03110, d);
    check("R7 write of 1 clears flag", d, 32'h0);
    check("R7 win_err cleared", 32'(win_err), 32'd0);
  endtask

  task automatic t_stall();
    int p = wr_cnt;
    stall = 1'b1;
    issue(1'b1, 20'h00400, 32'hCAFE_0400);
    for (int i = 0; i < 3; i++) begin
      check("R9 bus_valid held", 32'(bus_valid), 32'd1);
      check("R9 host_ready low", 32'(host_ready), 32'd0);
      check("R9 bus_addr stable", 32'(bus_addr), 32'h0000_0400);
      @(negedge clk);
    end
    stall = 1'b0;
    wait_wr(p);
    check("R9 write completes after stall", wr_data, 32'hCAFE_0400);
    @(negedge clk);
    check("R9 ready after completion", 32'(host_ready), 32'd1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_ctrl();
    t_window();
    t_back2back();
    t_disabled();
    t_sticky();
    t_stall();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule